// File: doc/BRIEF.md
# Single-Bit Sector ECC Checker

This block protects a 512-byte flash data sector with a 24-bit Hamming-style parity code. As the sector streams past one byte per cycle, it builds two 12-bit parity words. One word collects every set data bit's combined byte-address and bit-position value. The other collects the complement of that value. The inverted pair is the sector's code. The host stores this code beside the sector when writing and presents it again when reading.

On a read, the block compares the code it computed with the stored code and classifies the difference. The possible outcomes are:

- a clean sector;
- a single flipped data bit, reported with its byte offset, its bit index and a ready-made XOR mask for patching the byte in a sector buffer;
- a single flipped bit inside the stored code, where the data itself is good;
- an uncorrectable pattern.

The stored code may arrive before, during or after the data bytes. The verdict appears one cycle after both are present, together with a one-cycle done pulse.

Top module: `nand_ecc1_chk`

## Requirements
- R1: While reset is asserted and after it is released, `done` is 0, and `status`, `err_offset`, `err_bit` and `fix_mask` are all 0.
- R2: `calc_code` equals the bitwise inverse of {U, L}. U is the XOR, over every set data bit, of the 12-bit value {byte_address[8:0], bit_index[2:0]}. L is the XOR of the bitwise complement of that same value. U sits in bits 23:12 and L in bits 11:0. A stored code's first byte maps to bits 7:0.
- R3: The syndrome is `calc_code` XOR `code_in`. A zero syndrome gives status 0 (clean).
- R4: A nonzero syndrome whose bits 23:12 are the exact complement of its bits 11:0 is a data-bit error. In that case:
  - status is 1;
  - `err_offset` is syndrome bits 23:15;
  - `err_bit` is syndrome bits 14:12;
  - `fix_mask` has only bit `err_bit` set.
- R5: If a data-bit error points at a byte offset not below SECTOR_BYTES, status is 3 and the offset, bit and mask outputs are 0.
- R6: A syndrome with exactly one bit set gives status 2 (stored-code error). The offset, bit and mask outputs are 0.
- R7: Every other nonzero syndrome gives status 3 (uncorrectable), with offset, bit and mask outputs at 0.
- R8: `done` rises for exactly one cycle, on the cycle after the later of two events: acceptance of the sector's last byte, or capture of the stored code. The result outputs hold their values until the next `done`.
- R9: Bytes offered after a sector is complete are ignored until the next `sos`. They change neither `calc_code` nor the result.
- R10: `sos` starts a new sector. It clears the parity and the byte count, and a byte valid in the same cycle becomes byte 0. A partial sector is discarded this way.
- R11: `code_valid` captures `code_in` whether it comes before the first byte or after the last. The order does not change the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sos | input | 1 | Start of sector; qualifies the first byte |
| din_valid | input | 1 | Data byte valid |
| din | input | 8 | Sector data byte |
| code_valid | input | 1 | Stored code valid |
| code_in | input | 24 | Stored 24-bit code, first stored byte in bits 7:0 |
| done | output | 1 | One-cycle pulse with a new verdict |
| status | output | 2 | 0 clean, 1 data bit corrected, 2 code bit error, 3 uncorrectable |
| err_offset | output | 9 | Byte offset of the flipped data bit |
| err_bit | output | 3 | Bit index of the flipped data bit |
| fix_mask | output | 8 | XOR mask for the faulty byte |
| calc_code | output | 24 | Code computed over the bytes accepted so far |

## Verification
The hardest verdict to reach from the ports is the out-of-range data-bit error. With a 512-byte sector, every complementary syndrome decodes to an offset below 512, so this verdict cannot occur at the default size. The bench therefore runs a second instance with a 256-byte sector. It feeds that instance a stored code equal to the computed code XOR a complementary pattern naming byte 300, and checks it against the same pattern naming byte 10. Stored-code errors and double errors are produced by flipping chosen bits in the bench's own reference code or data after the reference is taken.

// File: rtl/nand_ecc1_pkg.sv
package nand_ecc1_pkg;

  localparam int CODE_W = 24;
  localparam int HALF_W = CODE_W / 2;
  localparam int BIT_W  = 3;
  localparam int ADDR_W = HALF_W - BIT_W;
  localparam int BYTE_W = 1 << BIT_W;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'd0,
    ST_FIXED    = 2'd1,
    ST_CODE_ERR = 2'd2,
    ST_UNCORR   = 2'd3
  } ecc_status_e;

  typedef struct packed {
    ecc_status_e        status;
    logic [ADDR_W-1:0]  offset;
    logic [BIT_W-1:0]   bit_idx;
  } ecc_result_t;

  // Parity of the byte bits whose index has bit k equal to 'want'.
  function automatic logic col_par(input logic [BYTE_W-1:0] d, input int k,
                                   input logic want);
    logic p;
    p = 1'b0;
    for (int i = 0; i < BYTE_W; i++) begin
      if (((i >> k) & 1) == int'(want)) p = p ^ d[i];
    end
    return p;
  endfunction

  // Contribution of one byte to the upper (want=1) or lower (want=0) half.
  function automatic logic [HALF_W-1:0] half_part(input logic [BYTE_W-1:0] d,
                                                  input logic [ADDR_W-1:0] a,
                                                  input logic want);
    logic [HALF_W-1:0] r;
    logic              p;
    p = ^d;
    for (int k = 0; k < BIT_W; k++) r[k] = col_par(d, k, want);
    for (int k = 0; k < ADDR_W; k++) r[BIT_W+k] = p & (a[k] == want);
    return r;
  endfunction

  function automatic logic [CODE_W-1:0] pack_code(input logic [HALF_W-1:0] hi,
                                                  input logic [HALF_W-1:0] lo);
    return ~{hi, lo};
  endfunction

  function automatic ecc_result_t classify(input logic [CODE_W-1:0] syn,
                                           input int unsigned sect);
    ecc_result_t       r;
    logic [HALF_W-1:0] fold;
    r = '0;
    fold = syn[CODE_W-1:HALF_W] ^ syn[HALF_W-1:0];
    if (syn == '0) begin
      r.status = ST_CLEAN;
    end else if (fold == {HALF_W{1'b1}}) begin
      if (32'(syn[CODE_W-1:HALF_W+BIT_W]) < sect) begin
        r.status  = ST_FIXED;
        r.offset  = syn[CODE_W-1:HALF_W+BIT_W];
        r.bit_idx = syn[HALF_W+BIT_W-1:HALF_W];
      end else begin
        r.status = ST_UNCORR;
      end
    end else if ($countones(syn) == 1) begin
      r.status = ST_CODE_ERR;
    end else begin
      r.status = ST_UNCORR;
    end
    return r;
  endfunction

endpackage

// File: rtl/ecc1_byte_seq.sv
module ecc1_byte_seq
  import nand_ecc1_pkg::*;
#(
  parameter int unsigned SECTOR_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sos,
  input  logic              din_valid,
  output logic              accept,
  output logic [ADDR_W-1:0] byte_addr,
  output logic              full
);
  localparam int CNT_W = $clog2(SECTOR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SECTOR_BYTES);

  logic [CNT_W-1:0] cnt;

  assign full      = (cnt == LAST);
  assign accept    = din_valid && (sos || !full);
  assign byte_addr = sos ? '0 : ADDR_W'(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (sos) begin
      cnt <= din_valid ? CNT_W'(1) : '0;
    end else if (accept) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R9
  AST_SOS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    sos && din_valid |=> cnt == CNT_W'(1)); // R10
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    full && !sos |=> full); // R9

endmodule

// File: rtl/ecc1_parity_acc.sv
module ecc1_parity_acc
  import nand_ecc1_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              accept,
  input  logic [BYTE_W-1:0] din,
  input  logic [ADDR_W-1:0] addr,
  output logic [HALF_W-1:0] hi,
  output logic [HALF_W-1:0] lo
);
  logic [HALF_W-1:0] part [2];

  // One contribution lane per half: lane 1 is the upper word, lane 0 the lower.
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign part[h] = half_part(din, addr, h[0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi <= '0;
      lo <= '0;
    end else if (accept) begin
      hi <= (clear ? '0 : hi) ^ part[1];
      lo <= (clear ? '0 : lo) ^ part[0];
    end else if (clear) begin
      hi <= '0;
      lo <= '0;
    end
  end

  AST_ACC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept && !clear |=> $stable(hi) && $stable(lo)); // R9
  AST_SOS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear && !accept |=> hi == '0 && lo == '0); // R10

endmodule

// File: rtl/ecc1_classify.sv
module ecc1_classify
  import nand_ecc1_pkg::*;
#(
  parameter int unsigned SECTOR_BYTES = 512
) (
  input  logic [CODE_W-1:0] calc,
  input  logic [CODE_W-1:0] stored,
  output logic [CODE_W-1:0] syn,
  output ecc_result_t       verdict
);
  assign syn     = calc ^ stored;
  assign verdict = classify(syn, SECTOR_BYTES);
endmodule

// File: rtl/nand_ecc1_chk.sv
module nand_ecc1_chk
  import nand_ecc1_pkg::*;
#(
  parameter int unsigned SECTOR_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sos,
  input  logic        din_valid,
  input  logic [7:0]  din,
  input  logic        code_valid,
  input  logic [23:0] code_in,
  output logic        done,
  output logic [1:0]  status,
  output logic [8:0]  err_offset,
  output logic [2:0]  err_bit,
  output logic [7:0]  fix_mask,
  output logic [23:0] calc_code
);
  logic              accept, full, fire;
  logic [ADDR_W-1:0] byte_addr;
  logic [HALF_W-1:0] acc_hi, acc_lo;
  logic [CODE_W-1:0] code_q, syn;
  logic              code_have, reported, done_q;
  ecc_result_t       verdict, res_q;

  ecc1_byte_seq #(.SECTOR_BYTES(SECTOR_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .sos(sos), .din_valid(din_valid),
    .accept(accept), .byte_addr(byte_addr), .full(full)
  );

  ecc1_parity_acc u_acc (
    .clk(clk), .rst_n(rst_n), .clear(sos), .accept(accept),
    .din(din), .addr(byte_addr), .hi(acc_hi), .lo(acc_lo)
  );

  assign calc_code = pack_code(acc_hi, acc_lo);

  ecc1_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_cls (
    .calc(calc_code), .stored(code_q), .syn(syn), .verdict(verdict)
  );

  // A verdict is due once the sector is complete and a stored code is held.
  assign fire = full && code_have && !reported;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q    <= '0;
      code_have <= 1'b0;
      reported  <= 1'b0;
      done_q    <= 1'b0;
      res_q     <= '0;
    end else begin
      done_q <= fire;
      if (code_valid) begin
        code_q    <= code_in;
        code_have <= 1'b1;
      end else if (fire) begin
        code_have <= 1'b0;
      end
      if (sos) reported <= 1'b0;
      else if (fire) reported <= 1'b1;
      if (fire) res_q <= verdict;
    end
  end

  assign done       = done_q;
  assign status     = res_q.status;
  assign err_offset = res_q.offset;
  assign err_bit    = res_q.bit_idx;

  for (genvar g = 0; g < BYTE_W; g++) begin : g_mask
    assign fix_mask[g] = (res_q.status == ST_FIXED) && (res_q.bit_idx == BIT_W'(g));
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(res_q)); // R8
  AST_FIX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    status == ST_FIXED |-> $countones(fix_mask) == 1); // R4
  AST_FIXED_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    status == ST_FIXED |-> 32'(err_offset) < SECTOR_BYTES); // R5
  AST_QUIET_UNLESS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    status != ST_FIXED |-> fix_mask == '0 && err_offset == '0 && err_bit == '0); // R6 R7
  AST_CODE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |=> code_have); // R11

endmodule

// File: tb/tb_nand_ecc1_chk.sv
`timescale 1ns/1ps
module tb_nand_ecc1_chk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sos = 1'b0, din_valid = 1'b0, code_valid = 1'b0;
  logic [7:0]  din = '0;
  logic [23:0] code_in = '0;
  logic        done, s_done;
  logic [1:0]  status, s_status;
  logic [8:0]  err_offset, s_offset;
  logic [2:0]  err_bit, s_bit;
  logic [7:0]  fix_mask, s_mask;
  logic [23:0] calc_code, s_calc;

  int checks = 0, failures = 0, cyc = 0;
  logic [7:0] mem [512];

  always #4 clk = ~clk;

  nand_ecc1_chk dut (
    .clk(clk), .rst_n(rst_n), .sos(sos), .din_valid(din_valid), .din(din),
    .code_valid(code_valid), .code_in(code_in), .done(done), .status(status),
    .err_offset(err_offset), .err_bit(err_bit), .fix_mask(fix_mask), .calc_code(calc_code)
  );

  nand_ecc1_chk #(.SECTOR_BYTES(256)) dut_small (
    .clk(clk), .rst_n(rst_n), .sos(sos), .din_valid(din_valid), .din(din),
    .code_valid(code_valid), .code_in(code_in), .done(s_done), .status(s_status),
    .err_offset(s_offset), .err_bit(s_bit), .fix_mask(s_mask), .calc_code(s_calc)
  );

  // {mode, arg[11:0] = {byte, bit} or code bit, seed}; odd seed sends the code first.
  // mode 0 clean, 1 one data flip, 2 one code flip, 3 two data flips, 4 two code flips
  localparam logic [23:0] VEC [10] = '{
    24'h000011, 24'h100022, 24'h1FFF33, 24'h180C44, 24'h200055,
    24'h201766, 24'h200C77, 24'h301988, 24'h400599, 24'h0000A2
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_code(input int len);
    logic [11:0] up, lo, x;
    up = '0; lo = '0;
    for (int a = 0; a < len; a++)
      for (int b = 0; b < 8; b++)
        if (mem[a][b]) begin
          x = {a[8:0], b[2:0]};
          up ^= x;
          lo ^= ~x;
        end
    return ~{up, lo};
  endfunction

  task automatic fill(input logic [7:0] seed);
    for (int i = 0; i < 512; i++) mem[i] = 8'((i * 29 + int'(seed) * 7) ^ (i >> 2));
  endtask

  task automatic send_sector(input int len);
    for (int i = 0; i < len; i++) begin
      din = mem[i]; din_valid = 1'b1; sos = (i == 0);
      @(negedge clk);
    end
    din_valid = 1'b0; sos = 1'b0;
  endtask

  task automatic send_code(input logic [23:0] c);
    code_in = c; code_valid = 1'b1;
    @(negedge clk);
    code_valid = 1'b0;
  endtask

  // Called at the negedge right after the last stimulus edge.
  task automatic expect_big(input string req, input logic [1:0] st, input logic [8:0] off,
                            input logic [2:0] bi, input logic [23:0] calc);
    chk("R8", "done early", 32'(done), 0);
    @(negedge clk);
    chk("R8", "done", 32'(done), 1);
    chk(req, "status", 32'(status), 32'(st));
    chk(req, "offset", 32'(err_offset), 32'(off));
    chk(req, "bit", 32'(err_bit), 32'(bi));
    chk(req, "mask", 32'(fix_mask), (st == 2'd1) ? (32'd1 << bi) : 32'd0);
    chk("R2", "calc_code", 32'(calc_code), 32'(calc));
    @(negedge clk);
    chk("R8", "done pulse width", 32'(done), 0);
  endtask

  initial begin
    logic [23:0] stored, calc;
    logic [11:0] x;
    logic [3:0]  mode;
    logic [11:0] arg;
    logic [1:0]  st;
    string       req;

    repeat (3) @(negedge clk);
    chk("R1", "done in reset", 32'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "done", 32'(done), 0);
    chk("R1", "status", 32'(status), 0);
    chk("R1", "offset/bit/mask", {20'(err_offset), 4'(err_bit), fix_mask}, 0);

    // Table walk
    foreach (VEC[n]) begin
      mode = VEC[n][23:20]; arg = VEC[n][19:8];
      fill(VEC[n][7:0]);
      stored = ref_code(512);
      case (mode)
        4'd1: begin mem[arg[11:3]][arg[2:0]] ^= 1'b1; st = 2'd1; req = "R4"; end
        4'd2: begin stored ^= 24'(1) << arg[4:0]; st = 2'd2; req = "R6"; end
        4'd3: begin
          mem[arg[11:3]][arg[2:0]] ^= 1'b1;
          x = arg ^ 12'h0A5;
          mem[x[11:3]][x[2:0]] ^= 1'b1;
          st = 2'd3; req = "R7";
        end
        4'd4: begin stored ^= (24'(1) << arg[4:0]) ^ (24'(1) << (arg[4:0] ^ 5'd7)); st = 2'd3; req = "R7"; end
        default: begin st = 2'd0; req = "R3"; end
      endcase
      calc = ref_code(512);
      if (VEC[n][0]) begin
        send_code(stored);           // R11 code first
        send_sector(512);
      end else begin
        send_sector(512);
        send_code(stored);
      end
      expect_big(req, st, (mode == 4'd1) ? arg[11:3] : 9'd0,
                 (mode == 4'd1) ? arg[2:0] : 3'd0, calc);
    end

    // R9: extra bytes after a full sector, no verdict without a code
    fill(8'h5C);
    calc = ref_code(512);
    send_sector(512);
    repeat (3) @(negedge clk);
    chk("R8", "no done without code", 32'(done), 0);
    for (int i = 0; i < 5; i++) begin
      din = 8'hE1 + 8'(i); din_valid = 1'b1; @(negedge clk);
    end
    din_valid = 1'b0;
    chk("R9", "calc after extra bytes", 32'(calc_code), 32'(calc));
    send_code(calc);
    expect_big("R9", 2'd0, 9'd0, 3'd0, calc);

    // R10: abandoned partial sector then a restart
    fill(8'h3D);
    for (int i = 0; i < 100; i++) begin
      din = 8'(i * 13 + 1); din_valid = 1'b1; sos = (i == 0); @(negedge clk);
    end
    din_valid = 1'b0; sos = 1'b0;
    calc = ref_code(512);
    send_sector(512);
    send_code(calc);
    expect_big("R10", 2'd0, 9'd0, 3'd0, calc);

    // R8/R11: code presented on the same cycle as the last byte
    fill(8'h77);
    calc = ref_code(512);
    mem[40][6] ^= 1'b1;
    for (int i = 0; i < 512; i++) begin
      din = mem[i]; din_valid = 1'b1; sos = (i == 0);
      code_valid = (i == 511); code_in = calc;
      @(negedge clk);
    end
    din_valid = 1'b0; code_valid = 1'b0;
    expect_big("R11", 2'd1, 9'd40, 3'd6, ref_code(512));

    // R5: out-of-range offset on a 256-byte instance
    fill(8'h19);
    calc = ref_code(256);
    x = {9'd300, 3'd2};
    send_sector(256);
    send_code(calc ^ {x, ~x});
    @(negedge clk);
    chk("R5", "small done", 32'(s_done), 1);
    chk("R5", "small status", 32'(s_status), 3);
    chk("R5", "small mask", {s_mask, 12'(s_offset)}, 0);
    x = {9'd10, 3'd5};
    send_sector(256);
    send_code(calc ^ {x, ~x});
    @(negedge clk);
    chk("R4", "small done", 32'(s_done), 1);
    chk("R4", "small status", 32'(s_status), 1);
    chk("R4", "small offset", 32'(s_offset), 10);
    chk("R4", "small bit", 32'(s_bit), 5);
    chk("R4", "small mask", 32'(s_mask), 32'h20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule